// File: doc/BRIEF.md
# Condition Flag Generator

This block produces the five processor condition flags (extend X, negative N, zero Z, overflow V and carry C) that follow an integer ALU operation. For each update it receives an operation class, an operand size, the source operand, the destination operand and the result the ALU produced. It then works out the new flags from those values alone. N and Z come from the result at the selected size. C and V come only from the most significant bits of source, destination and result. X follows C for additions and subtractions and is left alone otherwise.

The flags are held in a small register inside the block. An update is one beat on the `upd_valid` strobe. The block takes every beat in the cycle it is presented and never applies back-pressure, so there is no ready signal. While `upd_valid` is low the register holds its value. The `x_we` output is combinational and shows, in the same cycle as the beat, whether that beat will write X.

Top module: `ccg_top`

## Requirements
- R1: After reset is released, all five flags read 0.
- R2: The size code on `op_size` selects the sign bit: 0 selects bit 7 (byte), 1 selects bit 15 (word), and 2 or 3 select bit 31 (long). After an accepted beat, N equals that bit of `result`.
- R3: After an accepted beat, Z is 1 exactly when the bits of `result` at and below the selected sign bit are all zero. Bits of `result` above that position have no effect on Z.
- R4: For class 0 (add), with sign bits S of `src_opnd`, D of `dst_opnd` and R of `result`: C = S&D | ~R&D | S&~R, and V = S&D&~R | ~S&~D&R.
- R5: For class 1 (subtract): C = S&~D | R&~D | S&R, and V = ~S&D&~R | S&~D&R.
- R6: Class 2 (compare) gives the subtract C and V, and X keeps its previous value.
- R7: For classes 0 and 1, X takes the new value of C. `x_we` is 1 in the cycle of such a beat and 0 for every other beat or idle cycle.
- R8: Class 3 (logical) and the unused codes 4 to 7 set C and V to 0, update N and Z, and keep X unchanged.
- R9: In a cycle where `upd_valid` is low, all five flags keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Update beat; accepted on every cycle it is high |
| op_class | input | 3 | 0 add, 1 subtract, 2 compare, 3 logical, 4-7 unrecognised |
| op_size | input | 2 | 0 byte, 1 word, 2/3 long |
| src_opnd | input | DATA_W | Source operand |
| dst_opnd | input | DATA_W | Destination operand |
| result | input | DATA_W | ALU result |
| x_we | output | 1 | This beat writes X |
| flag_x | output | 1 | Extend flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The assertions assume only that the class and size inputs are driven to known values on every beat. They do not assume that `result` is really the sum or difference of the operands, so the flag equations must hold for any three input words. The stimulus therefore draws source, destination and result independently, which makes all eight sign-bit combinations occur at every size. It also clears the low bits of the result on a share of beats so that Z is set often, and leaves the upper bits set while doing so. Directed beats cover signed overflow at the byte boundary, a borrow out of zero, a compare that follows an X-setting add, every unrecognised class code, and idle gaps between beats.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

  // operation class codes
  localparam logic [2:0] OPC_ADD   = 3'd0;
  localparam logic [2:0] OPC_SUB   = 3'd1;
  localparam logic [2:0] OPC_CMP   = 3'd2;
  localparam logic [2:0] OPC_LOGIC = 3'd3;

  // operand size codes (3 decodes as long)
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

endpackage

// File: rtl/ccg_size_slice.sv
module ccg_size_slice #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        op_size,
  input  logic [DATA_W-1:0] src_opnd,
  input  logic [DATA_W-1:0] dst_opnd,
  input  logic [DATA_W-1:0] result,
  output logic              s_top,
  output logic              d_top,
  output logic              r_top,
  output logic              r_zero
);
  import ccg_pkg::*;

  localparam int IDX_W    = $clog2(DATA_W);
  localparam int BYTE_TOP = 7;
  localparam int WORD_TOP = 15;
  localparam int LONG_TOP = DATA_W - 1;

  logic [IDX_W-1:0]  top_idx;
  logic [IDX_W-1:0]  trim;
  logic [DATA_W-1:0] size_mask;

  always_comb begin
    case (op_size)
      SZ_BYTE: top_idx = IDX_W'(BYTE_TOP);
      SZ_WORD: top_idx = IDX_W'(WORD_TOP);
      default: top_idx = IDX_W'(LONG_TOP);
    endcase
  end

  assign trim      = IDX_W'(LONG_TOP) - top_idx;
  assign size_mask = {DATA_W{1'b1}} >> trim;

  assign s_top  = src_opnd[top_idx];
  assign d_top  = dst_opnd[top_idx];
  assign r_top  = result[top_idx];
  assign r_zero = ((result & size_mask) == '0);

  always_comb begin
    assert (!(r_zero && r_top)) else $error("AST_ZERO_NOT_NEG"); // R3
  end

endmodule

// File: rtl/ccg_cv_eval.sv
module ccg_cv_eval (
  input  logic [2:0] op_class,
  input  logic       s_top,
  input  logic       d_top,
  input  logic       r_top,
  output logic       c_nxt,
  output logic       v_nxt,
  output logic       x_wr
);
  import ccg_pkg::*;

  logic add_c, add_v, sub_c, sub_v;

  assign add_c = (s_top & d_top) | (~r_top & d_top) | (s_top & ~r_top);
  assign add_v = (s_top & d_top & ~r_top) | (~s_top & ~d_top & r_top);
  assign sub_c = (s_top & ~d_top) | (r_top & ~d_top) | (s_top & r_top);
  assign sub_v = (~s_top & d_top & ~r_top) | (s_top & ~d_top & r_top);

  always_comb begin
    case (op_class)
      OPC_ADD: begin c_nxt = add_c; v_nxt = add_v; x_wr = 1'b1; end
      OPC_SUB: begin c_nxt = sub_c; v_nxt = sub_v; x_wr = 1'b1; end
      OPC_CMP: begin c_nxt = sub_c; v_nxt = sub_v; x_wr = 1'b0; end
      default: begin c_nxt = 1'b0;  v_nxt = 1'b0;  x_wr = 1'b0; end
    endcase
  end

endmodule

// File: rtl/ccg_flag_reg.sv
module ccg_flag_reg (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic          x_wr,
  input  ccg_pkg::ccr_t nxt,
  output ccg_pkg::ccr_t cur
);
  import ccg_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (upd) begin
      cur.n <= nxt.n;
      cur.z <= nxt.z;
      cur.v <= nxt.v;
      cur.c <= nxt.c;
      if (x_wr) cur.x <= nxt.x;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !upd |=> $stable(cur)); // R9
  AST_X_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (upd && !x_wr) |=> $stable(cur.x)); // R8

endmodule

// File: rtl/ccg_top.sv
module ccg_top #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [2:0]        op_class,
  input  logic [1:0]        op_size,
  input  logic [DATA_W-1:0] src_opnd,
  input  logic [DATA_W-1:0] dst_opnd,
  input  logic [DATA_W-1:0] result,
  output logic              x_we,
  output logic              flag_x,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c
);
  import ccg_pkg::*;

  logic s_top, d_top, r_top, r_zero;
  logic c_nxt, v_nxt, x_wr;
  ccr_t nxt, cur;

  ccg_size_slice #(.DATA_W(DATA_W)) u_slice (
    .op_size  (op_size),
    .src_opnd (src_opnd),
    .dst_opnd (dst_opnd),
    .result   (result),
    .s_top    (s_top),
    .d_top    (d_top),
    .r_top    (r_top),
    .r_zero   (r_zero)
  );

  ccg_cv_eval u_cv (
    .op_class (op_class),
    .s_top    (s_top),
    .d_top    (d_top),
    .r_top    (r_top),
    .c_nxt    (c_nxt),
    .v_nxt    (v_nxt),
    .x_wr     (x_wr)
  );

  always_comb begin
    nxt.x = c_nxt;
    nxt.n = r_top;
    nxt.z = r_zero;
    nxt.v = v_nxt;
    nxt.c = c_nxt;
  end

  ccg_flag_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (upd_valid),
    .x_wr  (x_wr),
    .nxt   (nxt),
    .cur   (cur)
  );

  assign x_we   = upd_valid & x_wr;
  assign flag_x = cur.x;
  assign flag_n = cur.n;
  assign flag_z = cur.z;
  assign flag_v = cur.v;
  assign flag_c = cur.c;

  AST_X_FOLLOWS_C: assert property (@(posedge clk) disable iff (!rst_n) x_we |=> (flag_x == flag_c)); // R7
  AST_CMP_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n) (upd_valid && op_class == OPC_CMP) |=> $stable(flag_x)); // R6
  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (upd_valid && op_class >= OPC_LOGIC) |=> (!flag_c && !flag_v)); // R8
  AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !(flag_n && flag_z)); // R2

endmodule

// File: tb/ccg_top_test.sv
`timescale 1ns/1ps
module ccg_top_test;

  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              upd_valid = 1'b0;
  logic [2:0]        op_class = '0;
  logic [1:0]        op_size = '0;
  logic [DATA_W-1:0] src_opnd = '0;
  logic [DATA_W-1:0] dst_opnd = '0;
  logic [DATA_W-1:0] result = '0;
  logic x_we, flag_x, flag_n, flag_z, flag_v, flag_c;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [4:0] model;   // {x,n,z,v,c}

  always #2 clk = ~clk;

  ccg_top #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .op_class(op_class),
    .op_size(op_size), .src_opnd(src_opnd), .dst_opnd(dst_opnd), .result(result),
    .x_we(x_we), .flag_x(flag_x), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c)
  );

  function automatic int top_of(input logic [1:0] sz);
    if (sz == 2'd0) return 7;
    if (sz == 2'd1) return 15;
    return 31;
  endfunction

  function automatic logic [4:0] ref_flags(input logic [4:0] old, input logic [2:0] cls,
      input logic [1:0] sz, input logic [31:0] s, input logic [31:0] d, input logic [31:0] r);
    int t = top_of(sz);
    logic sb = s[t], db = d[t], rb = r[t];
    logic x = old[4], n, z, v, c;
    logic [31:0] m = 32'hFFFF_FFFF >> (31 - t);
    n = rb;
    z = ((r & m) == 32'd0);
    case (cls)
      3'd0: begin c = (sb&db)|(!rb&db)|(sb&!rb); v = (sb&db&!rb)|(!sb&!db&rb); x = c; end
      3'd1: begin c = (sb&!db)|(rb&!db)|(sb&rb); v = (!sb&db&!rb)|(sb&!db&rb); x = c; end
      3'd2: begin c = (sb&!db)|(rb&!db)|(sb&rb); v = (!sb&db&!rb)|(sb&!db&rb); end
      default: begin c = 1'b0; v = 1'b0; end
    endcase
    return {x, n, z, v, c};
  endfunction

  task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic beat(input string tag, input logic vld, input logic [2:0] cls,
      input logic [1:0] sz, input logic [31:0] s, input logic [31:0] d, input logic [31:0] r);
    logic [4:0] exp;
    upd_valid = vld; op_class = cls; op_size = sz;
    src_opnd = s; dst_opnd = d; result = r;
    #1;
    check({tag, " R7 x_we"}, {4'b0, x_we}, {4'b0, vld && (cls == 3'd0 || cls == 3'd1)});
    exp = vld ? ref_flags(model, cls, sz, s, d, r) : model;
    @(negedge clk);
    check(vld ? tag : "R9 idle", {flag_x, flag_n, flag_z, flag_v, flag_c}, exp);
    model = exp;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model = 5'b0;
    check("R1 reset", {flag_x, flag_n, flag_z, flag_v, flag_c}, 5'b0);

    // directed corners
    beat("R4 byte overflow", 1, 3'd0, 2'd0, 32'h01, 32'h7F, 32'h80);
    beat("R4 byte carry",    1, 3'd0, 2'd0, 32'hFF, 32'h81, 32'h80);
    beat("R6 cmp keeps X",   1, 3'd2, 2'd0, 32'h00, 32'h10, 32'h10);
    beat("R5 borrow",        1, 3'd1, 2'd0, 32'h01, 32'h00, 32'hFF);
    beat("R9 gap",           0, 3'd0, 2'd0, 32'h0, 32'h0, 32'h0);
    beat("R3 upper ignored", 1, 3'd3, 2'd0, 32'h0, 32'h0, 32'hFFFF_FF00);
    beat("R3 word zero",     1, 3'd3, 2'd1, 32'h0, 32'h0, 32'hABCD_0000);
    beat("R2 word neg",      1, 3'd0, 2'd1, 32'h0, 32'h0, 32'h0000_8000);
    beat("R2 long neg",      1, 3'd1, 2'd3, 32'h8000_0000, 32'h0, 32'h8000_0000);
    for (int k = 4; k < 8; k++)
      beat("R8 unknown class", 1, 3'(k), 2'd2, 32'hFFFF_FFFF, 32'h0, 32'h8000_0001);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  sz  = 2'($urandom_range(0, 3));
      logic [2:0]  cls = 3'($urandom_range(0, 7));
      logic [31:0] r   = $urandom;
      logic        vld = ($urandom_range(0, 9) < 8);
      if ($urandom_range(0, 5) == 0) r = r & ~(32'hFFFF_FFFF >> (31 - top_of(sz)));
      beat("R2 R3 R4 R5 R6 R8 random", vld, cls, sz, $urandom, $urandom, r);
    end

    upd_valid = 1'b0;
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule